// File: doc/BRIEF.md
# Cascaded Decimal Digit Counter

This block counts clock cycles in decimal. It is built from two identical digit stages. Each stage holds one binary-coded-decimal digit that steps from 0 to 9 and then returns to 0. All stages share one clock. The low digit advances on every enabled cycle. A higher digit advances only on a cycle in which every digit below it is at 9 and the count is enabled. The counter therefore runs 00, 01, … 99 and then 00 again. The two digits appear together on a packed byte.

Each stage raises a terminal-count flag when it sits at 9 and is allowed to advance. The flag of the highest stage leaves the block as a carry. A user can cascade further counters with it, or count decades of hundreds with it. A synchronous clear zeroes the whole count in one cycle. A synchronous reset does the same at start-up.

Top module: `bcd_cascade_counter`

## Requirements
- R1: A clock edge with `rst` high leaves `bcd_out` at 8'h00.
- R2: The low digit occupies `bcd_out[3:0]`. On an edge with `cnt_en` high and `clr` low it goes up by one, and from 9 it goes to 0.
- R3: The high digit occupies `bcd_out[7:4]`. It goes up by one only on an enabled edge on which the low digit wraps from 9 to 0. On every other edge without clear it keeps its value.
- R4: From a count of 99, an edge with `cnt_en` high and `clr` low gives 00.
- R5: `carry_out` is combinational. It is high exactly when `cnt_en` is high, `clr` is low and the count is 99.
- R6: While `cnt_en` is low and `clr` is low, both digits keep their values and `carry_out` stays low.
- R7: An edge with `clr` high zeroes both digits, whatever `cnt_en` is. While `clr` is high, `carry_out` is low.
- R8: Neither digit ever holds a value above 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all digit stages |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear of the count, active high, overrides enable |
| cnt_en | input | 1 | Count enable of the low digit |
| bcd_out | output | 8 | Packed count, high digit in bits 7:4, low digit in bits 3:0 |
| carry_out | output | 1 | Terminal count of the high digit, high on the cycle before a wrap from 99 |

## Verification
The properties assume that `clr` and `cnt_en` are steady around the sampling edge. They also assume that reset is applied before the first checked cycle. Under these conditions every digit starts from a legal decimal value. The stimulus changes both controls only on falling edges, and it begins with a reset cycle. From there it runs long enabled stretches that carry through both digit wraps. These stretches are mixed with held cycles, with clear pulses taken with enable high and with enable low, and with a stop at 99 under enable low.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;

    localparam int DIGIT_W = 4;
    localparam int RADIX   = 10;

    typedef logic [DIGIT_W-1:0] digit_t;

    localparam digit_t DIGIT_LAST = digit_t'(RADIX - 1);

    // Control seen by one digit stage
    typedef struct packed {
        logic clear;
        logic enable;
    } stage_ctl_t;

    function automatic digit_t digit_advance(input digit_t d);
        digit_t n;
        if (d == DIGIT_LAST) n = '0;
        else                 n = d + digit_t'(1);
        return n;
    endfunction

    function automatic logic digit_is_last(input digit_t d);
        return d == DIGIT_LAST;
    endfunction

endpackage

// File: rtl/bcd_terminal_detect.sv
module bcd_terminal_detect
    import bcd_cnt_pkg::*;
(
    input  digit_t value,
    input  logic   enable,
    output logic   tc
);

    always_comb begin
        tc = enable & digit_is_last(value);
    end

endmodule

// File: rtl/bcd_digit_stage.sv
module bcd_digit_stage
    import bcd_cnt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  stage_ctl_t ctl,
    output digit_t     value,
    output logic       tc
);

    digit_t value_q;

    always_ff @(posedge clk) begin
        if (rst || ctl.clear) begin
            value_q <= '0;
        end else if (ctl.enable) begin
            value_q <= digit_advance(value_q);
        end
    end

    assign value = value_q;

    bcd_terminal_detect u_tc (
        .value  (value_q),
        .enable (ctl.enable),
        .tc     (tc)
    );

endmodule

// File: rtl/bcd_enable_chain.sv
module bcd_enable_chain
    import bcd_cnt_pkg::*;
#(
    parameter int NUM_DIGITS = 2,
    localparam int VAL_W     = NUM_DIGITS * DIGIT_W
) (
    input  logic                  cnt_en,
    input  logic                  clr,
    input  logic [VAL_W-1:0]      values,
    output logic [NUM_DIGITS-1:0] stage_en
);

    // Stage i may advance when the block is enabled, not clearing,
    // and every stage below it sits at its last value.
    always_comb begin
        logic run;
        run = cnt_en & ~clr;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            stage_en[i] = run;
            run = run & digit_is_last(values[i*DIGIT_W +: DIGIT_W]);
        end
    end

endmodule

// File: rtl/bcd_cascade_counter.sv
module bcd_cascade_counter
    import bcd_cnt_pkg::*;
#(
    parameter int NUM_DIGITS = 2,
    localparam int OUT_W     = NUM_DIGITS * DIGIT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             cnt_en,
    output logic [OUT_W-1:0] bcd_out,
    output logic             carry_out
);

    logic [OUT_W-1:0]      values;
    logic [NUM_DIGITS-1:0] stage_en;
    logic [NUM_DIGITS-1:0] stage_tc;

    bcd_enable_chain #(.NUM_DIGITS(NUM_DIGITS)) u_chain (
        .cnt_en   (cnt_en),
        .clr      (clr),
        .values   (values),
        .stage_en (stage_en)
    );

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
        stage_ctl_t ctl;
        digit_t     val;

        assign ctl.clear  = clr;
        assign ctl.enable = stage_en[i];

        bcd_digit_stage u_stage (
            .clk   (clk),
            .rst   (rst),
            .ctl   (ctl),
            .value (val),
            .tc    (stage_tc[i])
        );

        assign values[i*DIGIT_W +: DIGIT_W] = val;
    end

    assign bcd_out   = values;
    assign carry_out = stage_tc[NUM_DIGITS-1];

endmodule

// File: rtl/bcd_cascade_counter_chk.sv
module bcd_cascade_counter_chk
    import bcd_cnt_pkg::*;
#(
    parameter int NUM_DIGITS = 2,
    localparam int OUT_W     = NUM_DIGITS * DIGIT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             cnt_en,
    input logic [OUT_W-1:0] bcd_out,
    input logic             carry_out
);

    localparam logic [OUT_W-1:0] ALL_LAST = {NUM_DIGITS{DIGIT_LAST}};

    digit_t lo_d, hi_d;
    assign lo_d = bcd_out[DIGIT_W-1:0];
    assign hi_d = bcd_out[2*DIGIT_W-1:DIGIT_W];

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> bcd_out == '0); // R1

    AST_LOW_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !clr && lo_d != DIGIT_LAST) |=> lo_d == $past(lo_d) + digit_t'(1)); // R2

    AST_LOW_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !clr && lo_d == DIGIT_LAST) |=> lo_d == '0); // R2

    AST_HIGH_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !clr && lo_d == DIGIT_LAST && hi_d != DIGIT_LAST) |=> hi_d == $past(hi_d) + digit_t'(1)); // R3

    AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr && !(cnt_en && lo_d == DIGIT_LAST)) |=> $stable(hi_d)); // R3

    AST_FULL_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !clr && bcd_out == ALL_LAST) |=> bcd_out == '0); // R4

    AST_CARRY_MATCH: assert property (@(posedge clk) disable iff (rst)
        carry_out == (cnt_en && !clr && bcd_out == ALL_LAST)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !clr) |=> $stable(bcd_out)); // R6

    AST_IDLE_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |-> !carry_out); // R6

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> bcd_out == '0); // R7

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_range
        AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
            bcd_out[i*DIGIT_W +: DIGIT_W] <= DIGIT_LAST); // R8
    end

endmodule

bind bcd_cascade_counter bcd_cascade_counter_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .cnt_en    (cnt_en),
    .bcd_out   (bcd_out),
    .carry_out (carry_out)
);

// File: tb/bcd_cascade_counter_test.sv
module bcd_cascade_counter_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic       cnt_en = 1'b0;
    logic [7:0] bcd_out;
    logic       carry_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    typedef struct {
        logic       exp_carry;
        logic [7:0] exp_bcd;
        string      tag;
    } item_t;

    item_t q[$];
    int model = 0;

    bcd_cascade_counter #(.NUM_DIGITS(2)) uut (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .cnt_en    (cnt_en),
        .bcd_out   (bcd_out),
        .carry_out (carry_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    // Driver: applies one cycle of control and pushes the expectation
    task automatic drive(input logic r, input logic en, input logic c, input string tag);
        item_t it;
        @(negedge clk);
        rst    = r;
        cnt_en = en;
        clr    = c;
        it.exp_carry = en && !c && !r && (model == 99);
        if (r || c)  model = 0;
        else if (en) model = (model + 1) % 100;
        it.exp_bcd = to_bcd(model);
        it.tag     = tag;
        q.push_back(it);
    endtask

    task automatic run(input int n, input logic en, input logic c, input string tag);
        for (int i = 0; i < n; i++) drive(1'b0, en, c, tag);
    endtask

    // Monitor: carry sampled mid low phase, count sampled after the edge
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (q.size() != 0) begin
                it = q.pop_front();
                checks++;
                if (carry_out !== it.exp_carry) begin
                    failures++;
                    $display("FAIL R5 (%s) carry_out=%b expected=%b", it.tag, carry_out, it.exp_carry);
                end
                @(posedge clk);
                #1;
                checks++;
                if (bcd_out !== it.exp_bcd) begin
                    failures++;
                    $display("FAIL %s bcd_out=%h expected=%h", it.tag, bcd_out, it.exp_bcd);
                end
                checks++;
                if (bcd_out[3:0] > 4'd9 || bcd_out[7:4] > 4'd9) begin
                    failures++;
                    $display("FAIL R8 bcd_out=%h expected digits <= 9", bcd_out);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired, checks=%0d expected completion", checks);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        drive(1'b1, 1'b0, 1'b0, "R1");
        drive(1'b1, 1'b1, 1'b0, "R1");
        run(9,  1'b1, 1'b0, "R2");          // 01..09
        run(4,  1'b1, 1'b0, "R3");          // 10..13, first high-digit step
        run(3,  1'b0, 1'b0, "R6");          // hold at 13
        drive(1'b0, 1'b1, 1'b1, "R7");      // clear beats enable
        run(99, 1'b1, 1'b0, "R3");          // up to 99
        run(2,  1'b0, 1'b0, "R6");          // hold at 99, no carry
        drive(1'b0, 1'b1, 1'b0, "R4");      // 99 -> 00 with carry
        run(5,  1'b1, 1'b0, "R2");
        for (int i = 0; i < 20; i++) drive(1'b0, i[0], 1'b0, "R6");
        drive(1'b0, 1'b0, 1'b1, "R7");      // clear with enable low
        run(99, 1'b1, 1'b0, "R2");          // to 99 again
        drive(1'b0, 1'b1, 1'b1, "R7");      // clear at 99: no carry
        run(99, 1'b1, 1'b0, "R3");
        drive(1'b0, 1'b1, 1'b0, "R4");
        drive(1'b1, 1'b1, 1'b0, "R1");      // reset mid count
        run(3, 1'b1, 1'b0, "R2");
        @(negedge clk);
        cnt_en = 1'b0;
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule